// File: doc/BRIEF.md
# Warp Limit Search Controller

This block runs inside one shader core and looks for the active-warp limit that gives the best instructions-per-cycle figure. A search is launched by a kernel-init pulse, which starts from the full warp total. It can also be launched by a start pulse, which starts from the limit the core is using now. The block then drives a trial limit to the warp scheduler. It waits a fixed number of period ticks for the IPC measured under that limit to settle. It compares the sample with the last stored one and moves to the next trial.

The search has two stages. A coarse stage halves or doubles the limit until IPC stops rising, and it may turn back once to search upward. A fine stage then steps the limit by one around the count recorded when the fine stage began. It can turn back once more, and it undoes its last step when IPC falls. When the search settles, the block gives a one-cycle done pulse together with the chosen count, and it holds the limit until the next launch.

Top module: `warp_limit_search`

## Requirements
- R1: After reset, `warp_limit_o` reads all ones, while `search_done_o` and `warp_final_o` read 0.
- R2: One cycle after a launch with a total of 2 or more, `warp_limit_o` shows the seed. The seed is the total for a kernel-init pulse, and kernel-init wins when both pulses arrive together. For a start pulse, the seed is `warp_cur_i` clamped to the range 1..total. The search starts in the coarse stage. Its direction is down, unless the seed is 1, in which case it is up. The stored IPC is cleared and the seed is recorded as the start count.
- R3: A launch with a total of 0 or 1 sets the limit to 1 and pulses done with a final count of 1 one cycle later.
- R4: A search step is evaluated only on a cycle with `period_tick_i` high. It happens on every SAMPLE_TICKS-th such tick counted from the launch. Cycles without a tick do not advance the count.
- R5: IPC counts as improved only when the new sample is strictly greater than the stored one. In the coarse stage, an improved sample is stored. The limit is then halved when moving down or doubled when moving up, and it is clamped to 1..total. The search ends instead if the limit is already 1 while moving down, or already at the total while moving up.
- R6: In the coarse stage, a sample that is not improved clears the stored IPC. If the limit equals half the start count, the direction becomes up and the limit returns to the start count. Otherwise the limit is doubled (clamped) only if the direction was down. That value becomes the start count, the direction becomes down and the fine stage begins.
- R7: In the fine stage, an improved sample is stored and the limit moves by one in the current direction. The search ends instead when the limit equals half the start count, equals twice the start count, exceeds the total, or sits at the range end in that direction.
- R8: In the fine stage, a sample that is not improved clears the stored IPC. If the limit equals the start count minus one, it returns to the start count and the direction becomes up. Otherwise the last one-step move is undone and the search ends.
- R9: When a search ends, `search_done_o` is high for exactly one cycle. `warp_final_o` equals `warp_limit_o` on that cycle. After that both values hold, and further ticks have no effect until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kernel_init_i | input | 1 | Launch pulse that seeds the search from the total |
| search_start_i | input | 1 | Launch pulse that seeds the search from `warp_cur_i` |
| warp_total_i | input | CNT_W | Total warps on the core, captured at launch |
| warp_cur_i | input | CNT_W | Limit in use now, the seed for `search_start_i` |
| ipc_sample_i | input | IPC_W | IPC measured under the current limit |
| period_tick_i | input | 1 | Sampling-period tick |
| warp_limit_o | output | CNT_W | Trial or settled active-warp limit (registered) |
| search_done_o | output | 1 | One-cycle pulse when the search settles |
| warp_final_o | output | CNT_W | Count chosen by the last search |

## Verification
A launch shows its seed on `warp_limit_o` at the first rising edge after the pulse. A total of 1 or less raises done at that same edge. Every later limit change, and the done pulse with its final count, appears on the edge that carries the SAMPLE_TICKS-th tick of a period. That edge lands at step count times SAMPLE_TICKS ticks after launch. The bench counts the ticks it drives, and in one scenario it drives ticks only on alternate cycles. It records the limit on each step edge and samples all outputs at the falling edge that follows. The expected trial sequences were worked out by hand from an IPC curve driven as a function of the current limit.

// File: rtl/wls_pkg.sv
package wls_pkg;
  typedef enum logic {
    MODE_COARSE = 1'b0,
    MODE_FINE   = 1'b1
  } mode_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/wls_period_timer.sv
module wls_period_timer #(
  parameter int SAMPLE_TICKS = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam int CW = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (run_i && tick_i) begin
      cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R4
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clear_i) |=> $stable(cnt_q))
    else $error("period count moved without a tick");
endmodule

// File: rtl/wls_count_move.sv
module wls_count_move #(
  parameter int W = 5
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] hi_i,
  input  logic         up_i,
  input  logic         coarse_i,
  output logic [W-1:0] nxt_o,
  output logic         blocked_o
);
  logic [W:0] cand;
  logic [W:0] hi_w;

  assign hi_w = {1'b0, hi_i};

  always_comb begin
    if (up_i) begin
      cand      = coarse_i ? {cnt_i, 1'b0} : ({1'b0, cnt_i} + (W+1)'(1));
      blocked_o = (cnt_i >= hi_i);
    end else begin
      if (cnt_i <= W'(1)) begin
        cand = (W+1)'(1);
      end else begin
        cand = coarse_i ? {1'b0, (cnt_i >> 1)} : ({1'b0, cnt_i} - (W+1)'(1));
      end
      blocked_o = (cnt_i <= W'(1));
    end
    if (cand > hi_w) begin
      cand = hi_w;
    end
    if (cand == '0) begin
      cand = (W+1)'(1);
    end
    nxt_o = cand[W-1:0];
  end
endmodule

// File: rtl/wls_step_eval.sv
module wls_step_eval
  import wls_pkg::*;
#(
  parameter int W     = 5,
  parameter int IPC_W = 16
) (
  input  mode_e            mode_i,
  input  dir_e             dir_i,
  input  logic [W-1:0]     nc_i,
  input  logic [W-1:0]     ns_i,
  input  logic [W-1:0]     tot_i,
  input  logic [IPC_W-1:0] prev_i,
  input  logic [IPC_W-1:0] now_i,
  output mode_e            mode_o,
  output dir_e             dir_o,
  output logic [W-1:0]     nc_o,
  output logic [W-1:0]     ns_o,
  output logic [IPC_W-1:0] prev_o,
  output logic             finish_o
);
  logic [W-1:0] fwd_nxt, undo_nxt, dbl_nxt;
  logic         fwd_blk, undo_blk, dbl_blk;
  logic         better;
  logic [W-1:0] half_ns;
  logic [W-1:0] ns_less1;
  logic [W:0]   twice_ns;

  // One step along the current direction, at the stage's granularity
  wls_count_move #(.W(W)) fwd_u (
    .cnt_i(nc_i), .hi_i(tot_i), .up_i(dir_i == DIR_UP),
    .coarse_i(mode_i == MODE_COARSE), .nxt_o(fwd_nxt), .blocked_o(fwd_blk)
  );

  // Reverse unit step used to undo the last fine move
  wls_count_move #(.W(W)) undo_u (
    .cnt_i(nc_i), .hi_i(tot_i), .up_i(dir_i == DIR_DOWN),
    .coarse_i(1'b0), .nxt_o(undo_nxt), .blocked_o(undo_blk)
  );

  // Doubling used when the coarse stage hands over to the fine stage
  wls_count_move #(.W(W)) dbl_u (
    .cnt_i(nc_i), .hi_i(tot_i), .up_i(1'b1),
    .coarse_i(1'b1), .nxt_o(dbl_nxt), .blocked_o(dbl_blk)
  );

  assign better   = (now_i > prev_i);
  assign half_ns  = ns_i >> 1;
  assign ns_less1 = ns_i - W'(1);
  assign twice_ns = {ns_i, 1'b0};

  always_comb begin
    mode_o   = mode_i;
    dir_o    = dir_i;
    nc_o     = nc_i;
    ns_o     = ns_i;
    prev_o   = prev_i;
    finish_o = 1'b0;
    if (mode_i == MODE_COARSE) begin
      if (better) begin
        prev_o = now_i;
        if (fwd_blk) begin
          finish_o = 1'b1;
        end else begin
          nc_o = fwd_nxt;
        end
      end else begin
        prev_o = '0;
        if (nc_i == half_ns) begin
          dir_o = DIR_UP;
          nc_o  = ns_i;
        end else begin
          nc_o   = (dir_i == DIR_DOWN) ? dbl_nxt : nc_i;
          ns_o   = (dir_i == DIR_DOWN) ? dbl_nxt : nc_i;
          dir_o  = DIR_DOWN;
          mode_o = MODE_FINE;
        end
      end
    end else begin
      if (better) begin
        prev_o = now_i;
        if ((nc_i == half_ns) || ({1'b0, nc_i} == twice_ns) ||
            (nc_i > tot_i) || fwd_blk) begin
          finish_o = 1'b1;
        end else begin
          nc_o = fwd_nxt;
        end
      end else begin
        prev_o = '0;
        if (nc_i == ns_less1) begin
          nc_o  = ns_i;
          dir_o = DIR_UP;
        end else begin
          nc_o     = undo_nxt;
          finish_o = 1'b1;
        end
      end
    end
  end

  logic unused_blk;
  assign unused_blk = undo_blk ^ dbl_blk;
endmodule

// File: rtl/warp_limit_search.sv
module warp_limit_search
  import wls_pkg::*;
#(
  parameter int CNT_W        = 5,
  parameter int IPC_W        = 16,
  parameter int SAMPLE_TICKS = 6250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kernel_init_i,
  input  logic             search_start_i,
  input  logic [CNT_W-1:0] warp_total_i,
  input  logic [CNT_W-1:0] warp_cur_i,
  input  logic [IPC_W-1:0] ipc_sample_i,
  input  logic             period_tick_i,
  output logic [CNT_W-1:0] warp_limit_o,
  output logic             search_done_o,
  output logic [CNT_W-1:0] warp_final_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             active_q;
  mode_e            mode_q;
  dir_e             dir_q;
  logic [CNT_W-1:0] nc_q, ns_q, tot_q, final_q;
  logic [IPC_W-1:0] prev_q;
  logic             done_q;

  logic             launch, fire;
  logic [CNT_W-1:0] tot_eff, cur_clamp, seed;

  mode_e            ev_mode;
  dir_e             ev_dir;
  logic [CNT_W-1:0] ev_nc, ev_ns;
  logic [IPC_W-1:0] ev_prev;
  logic             ev_finish;

  assign launch    = kernel_init_i | search_start_i;
  assign tot_eff   = (warp_total_i == '0) ? ONE : warp_total_i;
  assign cur_clamp = (warp_cur_i == '0) ? ONE :
                     (warp_cur_i > tot_eff) ? tot_eff : warp_cur_i;
  assign seed      = kernel_init_i ? tot_eff : cur_clamp;

  wls_period_timer #(.SAMPLE_TICKS(SAMPLE_TICKS)) timer_u (
    .clk(clk), .rst(rst), .clear_i(launch), .run_i(active_q),
    .tick_i(period_tick_i), .fire_o(fire)
  );

  wls_step_eval #(.W(CNT_W), .IPC_W(IPC_W)) eval_u (
    .mode_i(mode_q), .dir_i(dir_q), .nc_i(nc_q), .ns_i(ns_q), .tot_i(tot_q),
    .prev_i(prev_q), .now_i(ipc_sample_i),
    .mode_o(ev_mode), .dir_o(ev_dir), .nc_o(ev_nc), .ns_o(ev_ns),
    .prev_o(ev_prev), .finish_o(ev_finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= MODE_COARSE;
      dir_q    <= DIR_DOWN;
      nc_q     <= '1;
      ns_q     <= '1;
      tot_q    <= '1;
      prev_q   <= '0;
      final_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        tot_q  <= tot_eff;
        mode_q <= MODE_COARSE;
        prev_q <= '0;
        if (tot_eff == ONE) begin
          nc_q     <= ONE;
          ns_q     <= ONE;
          dir_q    <= DIR_UP;
          active_q <= 1'b0;
          done_q   <= 1'b1;
          final_q  <= ONE;
        end else begin
          nc_q     <= seed;
          ns_q     <= seed;
          dir_q    <= (seed == ONE) ? DIR_UP : DIR_DOWN;
          active_q <= 1'b1;
        end
      end else if (fire) begin
        mode_q <= ev_mode;
        dir_q  <= ev_dir;
        nc_q   <= ev_nc;
        ns_q   <= ev_ns;
        prev_q <= ev_prev;
        if (ev_finish) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          final_q  <= ev_nc;
        end
      end
    end
  end

  assign warp_limit_o  = nc_q;
  assign search_done_o = done_q;
  assign warp_final_o  = final_q;

  // R5
  limit_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (warp_limit_o >= ONE && warp_limit_o <= tot_q))
    else $error("trial limit left 1..total");

  // R4
  step_origin_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(warp_limit_o) |-> ($past(launch) || $past(fire)))
    else $error("limit changed without launch or step");

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (search_done_o && !launch) |=> !search_done_o)
    else $error("done held longer than one cycle");

  // R9
  final_match_chk: assert property (@(posedge clk) disable iff (rst)
    search_done_o |-> (warp_final_o == warp_limit_o))
    else $error("final count differs from limit at done");

  // R9
  limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !launch) |=> $stable(warp_limit_o))
    else $error("limit moved while settled");
endmodule

// File: tb/warp_limit_search_tb_top.sv
module warp_limit_search_tb_top;
  localparam int CW = 5;
  localparam int IW = 16;
  localparam int S  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          kernel_init_i = 1'b0;
  logic          search_start_i = 1'b0;
  logic [CW-1:0] warp_total_i = '0;
  logic [CW-1:0] warp_cur_i = '0;
  logic [IW-1:0] ipc_sample_i = '0;
  logic          period_tick_i = 1'b0;
  logic [CW-1:0] warp_limit_o;
  logic          search_done_o;
  logic [CW-1:0] warp_final_o;

  int checks = 0;
  int failures = 0;
  int curve_sel = 0;
  bit all_done = 1'b0;
  int trace [0:31];

  always #5 clk = ~clk;

  warp_limit_search #(.CNT_W(CW), .IPC_W(IW), .SAMPLE_TICKS(S)) dut_i (
    .clk(clk), .rst(rst), .kernel_init_i(kernel_init_i),
    .search_start_i(search_start_i), .warp_total_i(warp_total_i),
    .warp_cur_i(warp_cur_i), .ipc_sample_i(ipc_sample_i),
    .period_tick_i(period_tick_i), .warp_limit_o(warp_limit_o),
    .search_done_o(search_done_o), .warp_final_o(warp_final_o)
  );

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int curve(int sel, int n);
    case (sel)
      0: return 100 - absd(n, 8) * 5;
      1: return n * 4;
      2: return 100 - absd(n, 5) * 4;
      3: return 200 - n * 4;
      4: case (n)
           10: return 50;
           5: return 40;
           12: return 45;
           11: return 30;
           default: return 0;
         endcase
      default: return 50;
    endcase
  endfunction

  always @(negedge clk) ipc_sample_i <= IW'(curve(curve_sel, int'(warp_limit_o)));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch a search, run until done, check steps, final count and hold.
  task automatic run_search(input bit kinit, input bit start, input int total,
                            input int cur, input int sel, input bit gaps,
                            input int exp_seed, input int exp_steps,
                            input int exp_final, input string tag);
    int tk = 0;
    bit got = 1'b0;
    int edges = 0;
    curve_sel = sel;
    for (int i = 0; i < 32; i++) trace[i] = -1;
    warp_total_i = CW'(total);
    warp_cur_i = CW'(cur);
    kernel_init_i = kinit;
    search_start_i = start;
    period_tick_i = 1'b0;
    @(negedge clk);
    kernel_init_i = 1'b0;
    search_start_i = 1'b0;
    // R2 seed shown one edge after launch
    chk(int'(warp_limit_o) == exp_seed, {"R2 seed ", tag}, warp_limit_o, exp_seed);
    for (int e = 1; e <= 2000 && !got; e++) begin
      period_tick_i = gaps ? (e % 2 == 0) : 1'b1;
      @(negedge clk);
      edges++;
      if (period_tick_i) begin
        tk++;
        if (tk % S == 0 && tk / S <= 32) trace[tk / S - 1] = int'(warp_limit_o);
      end
      if (search_done_o) begin
        got = 1'b1;
        // R4 done lands on a tick edge
        chk(period_tick_i == 1'b1, {"R4 done on tick ", tag}, period_tick_i, 1);
      end
    end
    period_tick_i = 1'b0;
    // R4 step count in ticks
    chk(got && tk == exp_steps * S, {"R4 ticks to done ", tag}, tk, exp_steps * S);
    if (gaps) chk(edges == 2 * exp_steps * S, {"R4 idle cycles ignored ", tag}, edges, 2 * exp_steps * S);
    // R9 final count
    chk(int'(warp_final_o) == exp_final, {"R9 final ", tag}, warp_final_o, exp_final);
    chk(warp_limit_o == warp_final_o, {"R9 limit at done ", tag}, warp_limit_o, warp_final_o);
    // R9 hold afterwards
    for (int h = 0; h < 3 * S; h++) begin
      period_tick_i = 1'b1;
      @(negedge clk);
      if (search_done_o || int'(warp_limit_o) != exp_final) begin
        chk(1'b0, {"R9 hold ", tag}, warp_limit_o, exp_final);
        break;
      end
    end
    chk(!search_done_o && int'(warp_final_o) == exp_final, {"R9 held ", tag}, warp_final_o, exp_final);
    period_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    // R1
    chk(warp_limit_o == '1, "R1 limit", warp_limit_o, 31);
    chk(search_done_o == 1'b0, "R1 done", search_done_o, 0);
    chk(warp_final_o == '0, "R1 final", warp_final_o, 0);
  endtask

  task automatic t_single_warp();
    warp_total_i = CW'(1);
    kernel_init_i = 1'b1;
    @(negedge clk);
    kernel_init_i = 1'b0;
    // R3
    chk(search_done_o == 1'b1, "R3 done", search_done_o, 1);
    chk(warp_limit_o == CW'(1), "R3 limit", warp_limit_o, 1);
    chk(warp_final_o == CW'(1), "R3 final", warp_final_o, 1);
    @(negedge clk);
    chk(search_done_o == 1'b0, "R3 single pulse", search_done_o, 0);
  endtask

  task automatic t_peak_mid();
    run_search(1, 0, 16, 0, 0, 0, 16, 7, 8, "peak8");
    // R6 coarse miss away from half start: double back, go fine
    chk(trace[2] == 8, "R6 double back", trace[2], 8);
    // R7 fine step down by one
    chk(trace[3] == 7, "R7 fine step", trace[3], 7);
    // R8 miss at start-1 returns to start
    chk(trace[4] == 8, "R8 return to start", trace[4], 8);
    chk(trace[5] == 9, "R8 then steps up", trace[5], 9);
  endtask

  task automatic t_rising();
    // kernel init and start together: kernel init wins (R2)
    run_search(1, 1, 16, 3, 1, 1, 16, 3, 16, "rising");
    // R6 miss at half start turns up and returns to start
    chk(trace[1] == 16, "R6 turn up", trace[1], 16);
  endtask

  task automatic t_from_one();
    run_search(0, 1, 20, 1, 2, 0, 1, 9, 5, "from1");
    // R5 doubling upward from 1
    chk(trace[0] == 2, "R5 double 1", trace[0], 2);
    chk(trace[2] == 8, "R5 double 3", trace[2], 8);
    // R8 undo last fine step
    chk(trace[7] == 4, "R8 before undo", trace[7], 4);
  endtask

  task automatic t_falling();
    run_search(1, 0, 16, 0, 3, 0, 16, 5, 1, "falling");
    // R5 halving reaches 1 then ends at lower end
    chk(trace[3] == 1, "R5 halve to 1", trace[3], 1);
  endtask

  task automatic t_clamp();
    run_search(0, 1, 12, 10, 4, 0, 10, 7, 12, "clamp");
    // R5 doubling 10 clamps to total 12
    chk(trace[2] == 12, "R5 clamp", trace[2], 12);
    // R7 fine stage ends at the upper range end
    chk(trace[5] == 12, "R7 at total", trace[5], 12);
  endtask

  task automatic t_flat();
    // R5 ties are not improvements
    run_search(0, 1, 16, 6, 5, 0, 6, 8, 12, "flat");
    chk(trace[1] == 6, "R5 tie turns", trace[1], 6);
    chk(trace[6] == 13, "R7 step up", trace[6], 13);
  endtask

  task automatic t_start_clamp();
    // R2 start seed above total is clamped
    curve_sel = 1;
    warp_total_i = CW'(9);
    warp_cur_i = CW'(25);
    search_start_i = 1'b1;
    @(negedge clk);
    search_start_i = 1'b0;
    chk(warp_limit_o == CW'(9), "R2 seed clamp", warp_limit_o, 9);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!all_done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_warp();
    t_peak_mid();
    t_rising();
    t_from_one();
    t_falling();
    t_clamp();
    t_flat();
    t_start_clamp();
    all_done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule